// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Software Refill

This block translates virtual addresses to physical ones with no page-table walker in hardware. A lookup presents a virtual address, a load/store flag and the current process tag. The request is registered, and one cycle later the block reports one of four results: a hit with a physical address, a miss, a modify fault, or a kernel-region bypass. Pages are 4 KiB, so the low twelve address bits are never translated.

On a miss the block raises a refill request and latches the faulting virtual page number. Software then walks its own page table and installs one entry through a write port. Entries carry a process tag, so a context switch needs no flush. A global flag lets a single entry serve every process. A free-running down-counter offers software a replacement slot that skips the low, wired entries. Addresses whose top three bits equal the kernel tag skip the buffer entirely and are mapped by clearing those bits.

Top module: `tlb_top`

## Requirements
- R1: On a hit, `paddr_o` is the entry's 20-bit frame number above the 12 untranslated offset bits of the request. When no lookup result is valid, or on a miss, `paddr_o` is zero.
- R2: All 64 entries are compared in parallel, and an entry at any index from 0 to 63 can produce a hit.
- R3: A non-global entry matches only when its stored 6-bit process tag equals the `cur_asid_i` captured with the request.
- R4: An entry written with `wr_global_i` = 1 matches on its page number alone, whatever the process tag.
- R5: A lookup that matches no entry, outside the kernel region, raises `miss_o`. From the following cycle, `bad_vpn_o` holds that request's address bits [31:12] until the next miss.
- R6: When request address bits [31:29] equal 3'b100, the result is a bypass. `paddr_o` equals the address with those three bits cleared, and `miss_o`, `hit_o`, `mod_fault_o` and `multi_hit_o` all stay low.
- R7: A store (`req_store_i` = 1) that matches an entry whose writable flag is clear raises `mod_fault_o` instead of `hit_o`. A load to the same entry hits.
- R8: Reset clears every entry's valid flag, so every translated lookup misses. A write takes one clock edge, and a lookup requested in the same cycle as the write already sees the new entry.
- R9: `rand_idx_o` is 63 after reset and falls by one on every clock edge. From 8, the wired-entry count, it returns to 63, so it never selects entries 0 to 7.
- R10: If several entries match, the lowest-numbered one supplies the result and `multi_hit_o` is raised.
- R11: `resp_valid_o` is high in exactly the cycle after a request is presented with `req_valid_i` = 1. At most one of `hit_o`, `miss_o` and `mod_fault_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address |
| req_store_i | input | 1 | Request is a store |
| cur_asid_i | input | 6 | Current process tag |
| wr_en_i | input | 1 | Write one entry |
| wr_idx_i | input | 6 | Entry index written |
| wr_vpn_i | input | 20 | Virtual page number |
| wr_asid_i | input | 6 | Process tag of the entry |
| wr_pfn_i | input | 20 | Physical frame number |
| wr_global_i | input | 1 | Entry ignores the process tag |
| wr_valid_i | input | 1 | Entry valid flag |
| wr_writable_i | input | 1 | Entry permits stores |
| resp_valid_o | output | 1 | Lookup result valid |
| paddr_o | output | 32 | Physical address |
| hit_o | output | 1 | Translation hit |
| miss_o | output | 1 | Refill request |
| mod_fault_o | output | 1 | Store to a read-only page |
| multi_hit_o | output | 1 | More than one entry matched |
| bad_vpn_o | output | 20 | Page number of the last miss |
| rand_idx_o | output | 6 | Suggested replacement index |

## Verification
Directed cases check the edges: an empty buffer after reset, the first and last index, a process tag that matches and one that does not, a global entry under a foreign tag, a read-only page hit by a load and then by a store, two entries holding the same page, and a write in the same cycle as a lookup of it. A random phase follows. It draws page numbers and process tags from small pools, so hits, misses, tag conflicts and duplicate entries occur often. About one address in eight falls into the kernel region, which separates a bypass from a miss. The replacement counter is compared on every cycle, including each wrap from 8 back to 63.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PA_W   = 32;
  localparam int unsigned PG_W   = 12;
  localparam int unsigned N_ENT  = 64;
  localparam int unsigned ASID_W = 6;
  localparam int unsigned VPN_W  = VA_W - PG_W;
  localparam int unsigned PFN_W  = PA_W - PG_W;
  localparam int unsigned IDX_W  = $clog2(N_ENT);

  typedef struct packed {
    logic              valid;
    logic              glob;
    logic              wr;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  tlb_entry_t        wr_entry_i,
  input  logic [VPN_W-1:0]  cmp_vpn_i,
  input  logic [ASID_W-1:0] cmp_asid_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [N_ENT-1:0]  match_o,
  output tlb_entry_t        rd_entry_o
);
  tlb_entry_t ent_w [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    tlb_entry_t e_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    e_q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))      e_q <= wr_entry_i;
    end
    assign ent_w[g]   = e_q;
    assign match_o[g] = e_q.valid && (e_q.vpn == cmp_vpn_i) &&
                        (e_q.glob || (e_q.asid == cmp_asid_i));
  end

  assign rd_entry_o = ent_w[rd_idx_i];

  // R8: a written entry is readable at its index on the next cycle
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ent_w[$past(wr_idx_i)] == $past(wr_entry_i)) ||
                (wr_en_i && $past(wr_idx_i) == wr_idx_i));
endmodule

// File: rtl/tlb_first_match.sv
module tlb_first_match
  import tlb_pkg::*;
(
  input  logic [N_ENT-1:0] match_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             multi_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o   = |match_i;
  // clearing the lowest set bit leaves something only if two or more were set
  assign multi_o = |(match_i & (match_i - N_ENT'(1)));
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
  import tlb_pkg::*;
#(
  parameter int unsigned WIRED = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] rand_o
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENT - 1);
  localparam logic [IDX_W-1:0] BOT = IDX_W'(WIRED);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= TOP;
    else if (cnt_q == BOT) cnt_q <= TOP;
    else                   cnt_q <= cnt_q - IDX_W'(1);
  end

  assign rand_o = cnt_q;

  a_r9_rand_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rand_o == BOT) |=> (rand_o == TOP));
  a_r9_rand_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rand_o != BOT) |=> (rand_o == $past(rand_o) - IDX_W'(1)));
  a_r9_rand_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rand_o >= BOT);
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int unsigned WIRED   = 8,
  parameter int unsigned KR_W    = 3,
  parameter logic [KR_W-1:0] KR_TAG = 3'b100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic              req_store_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic              wr_global_i,
  input  logic              wr_valid_i,
  input  logic              wr_writable_i,
  output logic              resp_valid_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic              mod_fault_o,
  output logic              multi_hit_o,
  output logic [VPN_W-1:0]  bad_vpn_o,
  output logic [IDX_W-1:0]  rand_idx_o
);
  logic              req_v_q, store_q;
  logic [VA_W-1:0]   vaddr_q;
  logic [ASID_W-1:0] asid_q;
  logic [VPN_W-1:0]  bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_v_q <= 1'b0;
      store_q <= 1'b0;
      vaddr_q <= '0;
      asid_q  <= '0;
    end else begin
      req_v_q <= req_valid_i;
      if (req_valid_i) begin
        store_q <= req_store_i;
        vaddr_q <= req_vaddr_i;
        asid_q  <= cur_asid_i;
      end
    end
  end

  tlb_entry_t        wr_ent, sel_ent;
  logic [N_ENT-1:0]  match;
  logic [IDX_W-1:0]  sel_idx;
  logic              any_m, multi_m;

  assign wr_ent = '{valid: wr_valid_i, glob: wr_global_i, wr: wr_writable_i,
                    asid: wr_asid_i, vpn: wr_vpn_i, pfn: wr_pfn_i};

  tlb_entry_array u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_ent),
    .cmp_vpn_i  (vaddr_q[VA_W-1:PG_W]),
    .cmp_asid_i (asid_q),
    .rd_idx_i   (sel_idx),
    .match_o    (match),
    .rd_entry_o (sel_ent)
  );

  tlb_first_match u_prio (
    .match_i (match),
    .idx_o   (sel_idx),
    .any_o   (any_m),
    .multi_o (multi_m)
  );

  tlb_rand_idx #(.WIRED(WIRED)) u_rand (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rand_o (rand_idx_o)
  );

  logic bypass, xlate, ro_store;
  assign bypass   = req_v_q && (vaddr_q[VA_W-1 -: KR_W] == KR_TAG);
  assign xlate    = req_v_q && !bypass;
  assign ro_store = store_q && !sel_ent.wr;

  assign resp_valid_o = req_v_q;
  assign hit_o        = xlate && any_m && !ro_store;
  assign mod_fault_o  = xlate && any_m && ro_store;
  assign miss_o       = xlate && !any_m;
  assign multi_hit_o  = xlate && multi_m;

  always_comb begin
    if (bypass)           paddr_o = PA_W'(vaddr_q[VA_W-KR_W-1:0]);
    else if (xlate && any_m) paddr_o = {sel_ent.pfn, vaddr_q[PG_W-1:0]};
    else                  paddr_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bad_q <= '0;
    else if (miss_o) bad_q <= vaddr_q[VA_W-1:PG_W];
  end
  assign bad_vpn_o = bad_q;

  a_r1_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || mod_fault_o) |-> paddr_o[PG_W-1:0] == vaddr_q[PG_W-1:0]);
  a_r5_bad_vpn_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> bad_vpn_o == $past(vaddr_q[VA_W-1:PG_W]));
  a_r6_bypass_no_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |-> !(miss_o || hit_o || mod_fault_o || multi_hit_o));
  a_r10_lowest_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlate && any_m) |-> match[sel_idx] &&
      ((match & ((N_ENT'(1) << sel_idx) - N_ENT'(1))) == '0));
  a_r10_multi_implies_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> !miss_o);
  a_r11_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, miss_o, mod_fault_o}));
  a_r11_resp_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
endmodule

// File: tb/tlb_top_tb.sv
module tlb_top_tb;
  import tlb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WIRED = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_store = 1'b0;
  logic [VA_W-1:0]   req_vaddr = '0;
  logic [ASID_W-1:0] cur_asid = '0;
  logic              wr_en = 1'b0, wr_global = 1'b0, wr_valid = 1'b0, wr_writable = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [VPN_W-1:0]  wr_vpn = '0;
  logic [ASID_W-1:0] wr_asid = '0;
  logic [PFN_W-1:0]  wr_pfn = '0;
  logic              resp_valid, hit, miss, mod_fault, multi_hit;
  logic [PA_W-1:0]   paddr;
  logic [VPN_W-1:0]  bad_vpn;
  logic [IDX_W-1:0]  rand_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_store_i(req_store),
    .cur_asid_i(cur_asid),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_asid_i(wr_asid),
    .wr_pfn_i(wr_pfn), .wr_global_i(wr_global), .wr_valid_i(wr_valid),
    .wr_writable_i(wr_writable),
    .resp_valid_o(resp_valid), .paddr_o(paddr), .hit_o(hit), .miss_o(miss),
    .mod_fault_o(mod_fault), .multi_hit_o(multi_hit), .bad_vpn_o(bad_vpn),
    .rand_idx_o(rand_idx)
  );

  int checks = 0, errors = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench model
  logic              m_v [N_ENT], m_g [N_ENT], m_w [N_ENT];
  logic [ASID_W-1:0] m_a [N_ENT];
  logic [VPN_W-1:0]  m_vpn [N_ENT];
  logic [PFN_W-1:0]  m_pfn [N_ENT];
  logic [VPN_W-1:0]  exp_bad = '0;
  logic [IDX_W-1:0]  exp_rand = 6'd63;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) exp_rand <= 6'd63;
    else exp_rand <= (exp_rand == WIRED) ? 6'd63 : exp_rand - 6'd1;

  typedef struct {
    logic rv, h, m, f, mh;
    logic [31:0] pa;
  } exp_t;

  function automatic exp_t predict(logic v, logic [31:0] va, logic st, logic [5:0] as);
    exp_t e;
    int first = -1, cnt = 0;
    e = '{rv: v, h: 0, m: 0, f: 0, mh: 0, pa: 0};
    if (!v) return e;
    if (va[31:29] == 3'b100) begin
      e.pa = {3'b000, va[28:0]};
      return e;
    end
    for (int i = 0; i < N_ENT; i++)
      if (m_v[i] && m_vpn[i] == va[31:12] && (m_g[i] || m_a[i] == as)) begin
        if (first < 0) first = i;
        cnt++;
      end
    if (first < 0) begin e.m = 1; return e; end
    e.mh = (cnt > 1);
    e.pa = {m_pfn[first], va[11:0]};
    if (st && !m_w[first]) e.f = 1; else e.h = 1;
    return e;
  endfunction

  // one cycle: optional write and optional lookup, checked one edge later
  task automatic step(string req, logic do_wr, logic [5:0] wi, logic [19:0] wv,
                      logic [5:0] wa, logic [19:0] wp, logic wg, logic wvl, logic ww,
                      logic do_rd, logic [31:0] va, logic st, logic [5:0] as);
    exp_t e;
    @(negedge clk);
    wr_en = do_wr; wr_idx = wi; wr_vpn = wv; wr_asid = wa; wr_pfn = wp;
    wr_global = wg; wr_valid = wvl; wr_writable = ww;
    req_valid = do_rd; req_vaddr = va; req_store = st; cur_asid = as;
    @(posedge clk);
    if (do_wr) begin
      m_v[wi] = wvl; m_g[wi] = wg; m_w[wi] = ww; m_a[wi] = wa;
      m_vpn[wi] = wv; m_pfn[wi] = wp;
    end
    e = predict(do_rd, va, st, as);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk({req, " R11 resp_valid"}, resp_valid, e.rv);
    chk({req, " R1 paddr"}, paddr, e.pa);
    chk({req, " hit"}, hit, e.h);
    chk({req, " R5 miss"}, miss, e.m);
    chk({req, " R7 mod_fault"}, mod_fault, e.f);
    chk({req, " R10 multi_hit"}, multi_hit, e.mh);
    chk({req, " R5 bad_vpn"}, bad_vpn, exp_bad);
    chk({req, " R9 rand_idx"}, rand_idx, exp_rand);
    if (e.m) exp_bad = va[31:12];
  endtask

  task automatic wr(string req, int i, logic [19:0] v, logic [5:0] a, logic [19:0] p,
                    logic g, logic w);
    step(req, 1'b1, 6'(i), v, a, p, g, 1'b1, w, 1'b0, 32'h0, 1'b0, 6'h0);
  endtask

  task automatic rd(string req, logic [31:0] va, logic st, logic [5:0] as);
    step(req, 1'b0, 6'h0, 20'h0, 6'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1, va, st, as);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N_ENT; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_w[i] = 0; m_a[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
    end
    #(CLK_PERIOD * 2 + 2);
    chk("R9 reset rand", rand_idx, 32'd63);
    chk("R11 reset resp_valid", resp_valid, 0);
    rst_n = 1'b1;

    // R8: empty after reset
    rd("R8 empty", 32'h0040_1234, 1'b0, 6'd1);
    rd("R8 empty2", 32'h7fff_f000, 1'b1, 6'd0);
    // R2: ends of the array
    wr("R2 wr0", 0, 20'h00401, 6'd3, 20'h12345, 1'b0, 1'b1);
    wr("R2 wr63", 63, 20'h00777, 6'd3, 20'h0abcd, 1'b0, 1'b1);
    rd("R2 hit0", 32'h0040_1abc, 1'b0, 6'd3);
    rd("R2 hit63", 32'h0077_7fff, 1'b1, 6'd3);
    // R3: foreign process tag misses
    rd("R3 other asid", 32'h0040_1abc, 1'b0, 6'd4);
    // R4: global entry ignores tag
    wr("R4 wr glob", 20, 20'h10000, 6'd9, 20'h00042, 1'b1, 1'b1);
    rd("R4 glob asid9", 32'h1000_0010, 1'b0, 6'd9);
    rd("R4 glob asid33", 32'h1000_0020, 1'b0, 6'd33);
    // R7: read-only page
    wr("R7 wr ro", 30, 20'h20000, 6'd5, 20'h00055, 1'b0, 1'b0);
    rd("R7 load", 32'h2000_0abc, 1'b0, 6'd5);
    rd("R7 store", 32'h2000_0abc, 1'b1, 6'd5);
    // R6: kernel region
    rd("R6 bypass", 32'h9234_5678, 1'b0, 6'd0);
    rd("R6 bypass st", 32'h8000_0004, 1'b1, 6'd7);
    // R10: duplicate page, lowest wins
    wr("R10 wr9", 9, 20'h30000, 6'd1, 20'h00999, 1'b0, 1'b1);
    wr("R10 wr5", 5, 20'h30000, 6'd1, 20'h00555, 1'b0, 1'b1);
    rd("R10 dup", 32'h3000_0444, 1'b0, 6'd1);
    // R8: write and lookup in the same cycle
    step("R8 same cycle", 1'b1, 6'd40, 20'h40000, 6'd2, 20'h04444, 1'b0, 1'b1, 1'b1,
         1'b1, 32'h4000_0123, 1'b0, 6'd2);
    // R5: miss then bad_vpn checked in next step
    rd("R5 miss", 32'h5555_5123, 1'b0, 6'd2);
    rd("R5 after", 32'h4000_0001, 1'b0, 6'd2);
    // R9: idle cycles across wraps
    for (int k = 0; k < 130; k++)
      step("R9 idle", 1'b0, 6'h0, 20'h0, 6'h0, 20'h0, 1'b0, 1'b0, 1'b0,
           1'b0, 32'h0, 1'b0, 6'h0);
    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [19:0] vp;
      logic [31:0] va;
      vp = {17'h00001 + 17'($urandom_range(0, 1)), 3'($urandom_range(0, 7))};
      va = {vp, 12'($urandom)};
      if ($urandom_range(0, 7) == 0) va[31:29] = 3'b100;
      step("R2 random", ($urandom_range(0, 2) == 0), 6'($urandom),
           {17'h00001 + 17'($urandom_range(0, 1)), 3'($urandom_range(0, 7))},
           6'($urandom_range(0, 3)), 20'($urandom), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 3) != 0), va, 1'($urandom), 6'($urandom_range(0, 3)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule